// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block stretches each external bus access by a programmed number of wait cycles and can then keep stretching it for as long as an external device requests more time. A controller pulses a start strobe together with the 4-bit wait setting, the interface mode (plain SRAM-style or multiplexed address/data), the transfer direction and a flag telling whether this beat is the first one of the transfer. The block raises a wait-active level for every stretched cycle and then gives a one-clock done pulse.

In SRAM-style mode the setting is decoded through a non-linear table. The waits apply to the first beat only, and a setting of zero switches off the external wait request. In multiplexed mode the setting is split into two fields. The low field gives the first-beat waits, which depend on the direction. A separate bit gives the waits for later beats. In this mode the external request is always honoured.

Top module: `wait_state_gen`

## Requirements
- R1: After a synchronous active-high reset, and whenever no access is running, `waitActive` and `accessDone` are 0.
- R2: SRAM-style mode (`muxMode`=0), first beat: setting values 0 to 9 give exactly that many wait cycles.
- R3: SRAM-style mode, first beat: settings 10, 11, 12, 13, 14 and 15 give 11, 13, 15, 17, 21 and 25 wait cycles.
- R4: SRAM-style mode with setting 0: `extWaitN` is ignored, and the done pulse comes on the cycle after the start strobe even while `extWaitN` is low.
- R5: SRAM-style mode, later beat (`laterBeat`=1): no programmed waits. `extWaitN` is honoured when the setting is nonzero.
- R6: Multiplexed mode (`muxMode`=1): bit 3 of the setting has no effect, and `extWaitN` is honoured for every setting.
- R7: Multiplexed mode, later beat: setting bit 2 = 0 gives 0 waits, and bit 2 = 1 gives 1 wait.
- R8: Multiplexed mode, first beat: setting bits 1:0 give the waits. 00 gives 1 on a read and 0 on a write (`isWrite`=1). 01, 10 and 11 give 1, 2 and 3 in both directions.
- R9: When `extWaitN` is honoured, it is sampled on the cycle in which the programmed waits run out (or on the start cycle when they are zero). Each cycle it is sampled low adds one more wait cycle.
- R10: `waitActive` is high on exactly the wait cycles. `accessDone` is a one-cycle pulse on the cycle after the last wait cycle, and it never overlaps `waitActive`.
- R11: Setting, mode, direction and beat flag are captured at the start strobe. A change to them during the access has no effect on its length.
- R12: A start strobe that arrives while an access is in progress, including its done cycle, is ignored.
- R13: Reset during an access abandons it: no done pulse follows, and the outputs return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| waitCode | input | 4 | Wait setting |
| muxMode | input | 1 | 0 = SRAM-style, 1 = multiplexed address/data |
| startStrb | input | 1 | Access start, one cycle |
| isWrite | input | 1 | 1 = write, 0 = read |
| laterBeat | input | 1 | 1 = second or later beat of a transfer |
| extWaitN | input | 1 | External wait request, active low |
| waitActive | output | 1 | High during each wait cycle |
| accessDone | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench covers the table jump from 9 to 11 waits and the top code of 25. A design that decoded the table linearly would finish those accesses early. It holds `extWaitN` low with setting 0 in SRAM-style mode, which a design that always honoured the pin would stretch. It also holds the pin low in multiplexed mode, where the write with setting 00 has zero waits and would wrongly finish at once if the pin were ignored. The bench changes the setting in mid-access, which exposes a design that failed to latch it. It fires a start strobe during the done cycle, which catches a design that relaunched early. It also resets in mid-access and checks that no stray done pulse appears.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXT  = 2'd2,
    ST_DONE = 2'd3
  } wsgState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture setting and load counter
    logic dec;    // count one programmed wait down
    logic busy;   // an access is in progress
  } wsgCtl_t;

  localparam int MAX_WAITS = 25;

  // SRAM-style table: linear up to 9, then non-linear steps
  function automatic logic [7:0] sramWaits(input logic [3:0] code);
    logic [7:0] r;
    case (code)
      4'd10:   r = 8'd11;
      4'd11:   r = 8'd13;
      4'd12:   r = 8'd15;
      4'd13:   r = 8'd17;
      4'd14:   r = 8'd21;
      4'd15:   r = 8'd25;
      default: r = {4'd0, code};
    endcase
    return r;
  endfunction

  // multiplexed mode: bit2 -> later beats, bits1:0 -> first beat
  function automatic logic [7:0] muxWaits(input logic [3:0] code,
                                          input logic later,
                                          input logic wr);
    logic [7:0] r;
    if (later)
      r = {7'd0, code[2]};
    else if (code[1:0] == 2'b00)
      r = wr ? 8'd0 : 8'd1;
    else
      r = {6'd0, code[1:0]};
    return r;
  endfunction
endpackage

// File: rtl/wsg_datapath.sv
module wsg_datapath
  import wsg_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 5
)(
  input  logic              clk,
  input  logic              rst,
  input  wsgCtl_t           ctl,
  input  logic [CODE_W-1:0] waitCode,
  input  logic              muxMode,
  input  logic              isWrite,
  input  logic              laterBeat,
  output logic              liveZero,
  output logic              liveHonor,
  output logic              cntOne,
  output logic              honorQ
);
  localparam logic [CODE_W-1:0] CODE_RST = '1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  liveCount;
  logic [CODE_W-1:0] cfgQ;
  logic              modeQ;
  logic [7:0]        rawCount;

  always_comb begin
    if (muxMode)
      rawCount = muxWaits(waitCode[3:0], laterBeat, isWrite);
    else if (laterBeat)
      rawCount = 8'd0;
    else
      rawCount = sramWaits(waitCode[3:0]);
    liveCount = rawCount[CNT_W-1:0];
  end

  assign liveZero  = (liveCount == '0);
  assign liveHonor = muxMode || (waitCode != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      cfgQ  <= CODE_RST;
      modeQ <= 1'b0;
    end else if (ctl.load) begin
      cnt   <= liveCount;
      cfgQ  <= waitCode;
      modeQ <= muxMode;
    end else if (ctl.dec) begin
      cnt   <= cnt - 1'b1;
    end
  end

  assign cntOne = (cnt == CNT_W'(1));
  assign honorQ = modeQ || (cfgQ != '0);

  // R11: captured setting frozen while busy
  p_cfg_held_r11: assert property (@(posedge clk) disable iff (rst)
    (ctl.busy && !ctl.load) |=> ($stable(cfgQ) && $stable(modeQ)));
  // R3: counter never exceeds table maximum
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_WAITS));
  // R10: counter only moves down during waits
  p_cnt_down_r10: assert property (@(posedge clk) disable iff (rst)
    ctl.dec |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/wsg_ctrl.sv
module wsg_ctrl
  import wsg_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    startStrb,
  input  logic    extWaitN,
  input  logic    liveZero,
  input  logic    liveHonor,
  input  logic    cntOne,
  input  logic    honorQ,
  output wsgCtl_t ctl,
  output logic    waitActive,
  output logic    accessDone
);
  wsgState_e state, stateNx;

  always_comb begin
    stateNx = state;
    unique case (state)
      ST_IDLE: if (startStrb) begin
        if (!liveZero)
          stateNx = ST_WAIT;
        else if (liveHonor && !extWaitN)
          stateNx = ST_EXT;
        else
          stateNx = ST_DONE;
      end
      ST_WAIT: if (cntOne)
        stateNx = (honorQ && !extWaitN) ? ST_EXT : ST_DONE;
      ST_EXT:  if (extWaitN) stateNx = ST_DONE;
      ST_DONE: stateNx = ST_IDLE;
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNx;
  end

  always_comb begin
    ctl.load = (state == ST_IDLE) && startStrb;
    ctl.dec  = (state == ST_WAIT);
    ctl.busy = (state != ST_IDLE);
  end

  assign waitActive = (state == ST_WAIT) || (state == ST_EXT);
  assign accessDone = (state == ST_DONE);

  // R10: done is a single-cycle pulse
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    accessDone |=> !accessDone);
  // R10: end of waiting leads straight to done
  p_wait_to_done_r10: assert property (@(posedge clk) disable iff (rst)
    (waitActive && stateNx == ST_IDLE) |-> 1'b0);
  // R4: external extension only when the pin is honoured
  p_ext_honoured_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXT) |-> honorQ);
  // R12: a start while busy does not restart the access
  p_start_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && startStrb) |=> (state == ST_IDLE));
  // R13: reset returns to idle
  p_reset_idle_r13: assert property (@(posedge clk)
    rst |=> (!waitActive && !accessDone));
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
  import wsg_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 5
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] waitCode,
  input  logic              muxMode,
  input  logic              startStrb,
  input  logic              isWrite,
  input  logic              laterBeat,
  input  logic              extWaitN,
  output logic              waitActive,
  output logic              accessDone
);
  wsgCtl_t ctl;
  logic liveZero, liveHonor, cntOne, honorQ;

  wsg_datapath #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .waitCode(waitCode), .muxMode(muxMode), .isWrite(isWrite),
    .laterBeat(laterBeat), .liveZero(liveZero), .liveHonor(liveHonor),
    .cntOne(cntOne), .honorQ(honorQ)
  );

  wsg_ctrl u_ctl (
    .clk(clk), .rst(rst), .startStrb(startStrb), .extWaitN(extWaitN),
    .liveZero(liveZero), .liveHonor(liveHonor), .cntOne(cntOne),
    .honorQ(honorQ), .ctl(ctl), .waitActive(waitActive),
    .accessDone(accessDone)
  );

  // R10: outputs never overlap
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    !(waitActive && accessDone));
endmodule

// File: tb/sim_wait_state_gen.sv
`timescale 1ns/1ps
module sim_wait_state_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] waitCode = 4'd0;
  logic muxMode = 1'b0, startStrb = 1'b0, isWrite = 1'b0;
  logic laterBeat = 1'b0, extWaitN = 1'b1;
  logic waitActive, accessDone;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  wait_state_gen u0 (
    .clk(clk), .rst(rst), .waitCode(waitCode), .muxMode(muxMode),
    .startStrb(startStrb), .isWrite(isWrite), .laterBeat(laterBeat),
    .extWaitN(extWaitN), .waitActive(waitActive), .accessDone(accessDone)
  );

  // expected number of programmed waits, from the requirements
  function automatic int expWaits(input logic [3:0] c, input logic m,
                                  input logic w, input logic l);
    int t[16] = '{0,1,2,3,4,5,6,7,8,9,11,13,15,17,21,25};
    if (!m) return l ? 0 : t[c];
    if (l) return c[2] ? 1 : 0;
    if (c[1:0] == 2'b00) return w ? 0 : 1;
    return int'(c[1:0]);
  endfunction

  // behavioural reference: phase 0 idle, 1 waiting, 2 extended, 3 done
  int mPhase = 0;
  int mLeft = 0;
  bit mHonor = 0;
  always @(posedge clk) begin
    int n;
    if (rst) mPhase = 0;
    else begin
      case (mPhase)
        0: if (startStrb) begin
          n = expWaits(waitCode, muxMode, isWrite, laterBeat);
          mHonor = muxMode || (waitCode != 0);
          if (n == 0) mPhase = (mHonor && !extWaitN) ? 2 : 3;
          else begin mPhase = 1; mLeft = n; end
        end
        1: begin
          mLeft = mLeft - 1;
          if (mLeft == 0) mPhase = (mHonor && !extWaitN) ? 2 : 3;
        end
        2: if (extWaitN) mPhase = 3;
        default: mPhase = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R10 (and R1, R12, R13 through the model): compare every cycle
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(waitActive == (mPhase == 1 || mPhase == 2), "R10 model waitActive",
            int'(waitActive), int'(mPhase == 1 || mPhase == 2));
      check(accessDone == (mPhase == 3), "R10 model accessDone",
            int'(accessDone), int'(mPhase == 3));
    end
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Launch one access; extWaitN is held low until holdK wait cycles were seen.
  // Optionally change the setting mid-access (R11) or pulse start during done (R12).
  task automatic runAcc(input logic [3:0] c, input logic m, input logic w,
                        input logic l, input int holdK, input int expected,
                        input string tag, input bit disturb = 0);
    int seen = 0;
    int got = -1;
    @(negedge clk);
    waitCode = c; muxMode = m; isWrite = w; laterBeat = l;
    extWaitN = (holdK > 0) ? 1'b0 : 1'b1;
    startStrb = 1'b1;
    @(negedge clk);
    startStrb = 1'b0;
    for (int i = 1; i < 80; i++) begin
      if (accessDone) begin
        got = i - 1;
        if (disturb) startStrb = 1'b1;
        break;
      end
      if (waitActive) seen++;
      if (seen >= holdK) extWaitN = 1'b1;
      if (disturb) begin waitCode = ~c; muxMode = ~m; isWrite = ~w; end
      @(negedge clk);
    end
    check(got == expected, tag, got, expected);
    @(negedge clk);
    startStrb = 1'b0;
    extWaitN = 1'b1;
    check(!waitActive && !accessDone, {tag, " idle after"}, int'(waitActive), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!waitActive && !accessDone, "R1 reset state", int'(waitActive | accessDone), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!waitActive && !accessDone, "R1 idle", int'(waitActive | accessDone), 0);

    for (int k = 0; k < 10; k++)
      runAcc(4'(k), 0, 0, 0, 0, k, $sformatf("R2 sram code %0d", k));
    runAcc(4'd10, 0, 0, 0, 0, 11, "R3 sram code 10");
    runAcc(4'd11, 0, 1, 0, 0, 13, "R3 sram code 11");
    runAcc(4'd12, 0, 0, 0, 0, 15, "R3 sram code 12");
    runAcc(4'd13, 0, 0, 0, 0, 17, "R3 sram code 13");
    runAcc(4'd14, 0, 0, 0, 0, 21, "R3 sram code 14");
    runAcc(4'd15, 0, 0, 0, 0, 25, "R3 sram code 15");

    runAcc(4'd0, 0, 0, 0, 5, 0, "R4 sram code 0 ignores pin");
    runAcc(4'd7, 0, 0, 1, 0, 0, "R5 sram later beat");
    runAcc(4'd7, 0, 0, 1, 3, 3, "R5 sram later beat pin honoured");

    runAcc(4'b1011, 1, 0, 0, 0, 3, "R6 mux bit3 ignored");
    runAcc(4'b1000, 1, 1, 0, 4, 4, "R6 mux code 0 pin honoured");
    runAcc(4'b0000, 1, 0, 1, 0, 0, "R7 mux later bit2=0");
    runAcc(4'b0100, 1, 1, 1, 0, 1, "R7 mux later bit2=1");
    runAcc(4'b0000, 1, 0, 0, 0, 1, "R8 mux 00 read");
    runAcc(4'b0000, 1, 1, 0, 0, 0, "R8 mux 00 write");
    runAcc(4'b0001, 1, 1, 0, 0, 1, "R8 mux 01 write");
    runAcc(4'b0010, 1, 0, 0, 0, 2, "R8 mux 10 read");
    runAcc(4'b0011, 1, 1, 0, 0, 3, "R8 mux 11 write");

    runAcc(4'd3, 0, 0, 0, 7, 7, "R9 pin extends past programmed");
    runAcc(4'd5, 0, 0, 0, 2, 5, "R9 pin released early no effect");

    runAcc(4'd6, 0, 0, 0, 0, 6, "R11 setting change mid-access", 1);
    runAcc(4'd2, 0, 0, 0, 0, 2, "R12 start during done ignored", 1);

    // R13: reset in the middle of an access
    @(negedge clk);
    waitCode = 4'd9; muxMode = 0; laterBeat = 0; startStrb = 1'b1;
    @(negedge clk);
    startStrb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 12; i++) begin
      check(!waitActive && !accessDone, "R13 abandoned after reset",
            int'(waitActive | accessDone), 0);
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule